// File: doc/BRIEF.md
# Configurable Memory-Mapped GPIO Controller

This block is a general-purpose I/O peripheral reached over a simple single-cycle register bus. The number of lines equals the register width (8, 16, 32 or 64). A bus write is taken when `sel_i` and `wr_i` are both high at a rising clock edge. Read data is combinational on `addr_i`. Each line has an output-value bit, an output-enable bit and a synchronised input sample.

Elaboration parameters choose how outputs are written. The first choice is a single data register that is read and written. The second is a pair of set and clear registers. The third is a set register that alone holds the whole output value. The direction register may be absent, may use output polarity, or may use input polarity. The bus view can mirror line order so that line 0 sits in the most significant bit, and it can swap byte order. Both apply to every register. The set register can also return a mixed view: the output latch for output lines and the pin state for input lines. An input-only variant ignores all output writes.

Register word addresses: 0 = data, 1 = set, 2 = clear, 3 = direction.

Top module: `gpio_ctrl`

## Requirements
- R1: The line count equals `WIDTH`, which must be 8, 16, 32 or 64. Byte swapping together with a width of 64 is rejected at elaboration. Line `WIDTH-1` is driven like any other line.
- R2: While reset is low, `out_o` is all zeros. When a direction register is present, `oe_o` is also all zeros, so every line is an input.
- R3: Reading the data register (address 0) returns the input pins through a two-flop synchroniser. A pin change made between two edges appears in `rdata_o` after the second of the following edges.
- R4: In set/clear style, a 1 in a set-register write (address 1) drives that line high. A 1 in a clear-register write (address 2) drives that line low. Zero bits leave their lines unchanged. The clear register reads as zero.
- R5: In set-only style, a write to the set register loads the full output value. A 0 bit drives its line low.
- R6: In data-register style, a write to address 0 loads the full output value. A read of address 0 still returns the synchronised pins.
- R7: A write changes `out_o` and `oe_o` at the edge that samples it. Bus cycles with `sel_i` low, and writes to registers absent in the chosen style, change nothing.
- R8: With an output-polarity direction register (address 3), a 1 bit makes the line an output (`oe_o` high). The register reads back as written.
- R9: With an input-polarity direction register, a 1 bit makes the line an input. `oe_o` is the complement of the written value, and the register reads back in its own encoding, so it reads all ones after reset.
- R10: With no direction register, `oe_o` is all ones and the direction address reads zero.
- R11: With mirroring on, line n maps to register bit `WIDTH-1-n` in every register.
- R12: With byte swap on, the byte order of the register view is reversed in every register.
- R13: With set readback on, reading the set register returns the output latch for output lines and the synchronised pin for input lines. With it off, the set register returns the output latch.
- R14: With the input-only option, `out_o` and `oe_o` stay zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Write strobe (qualified by sel_i) |
| addr_i | input | 2 | Register word address |
| wdata_i | input | WIDTH | Write data, bus view |
| rdata_o | output | WIDTH | Read data, bus view |
| pins_i | input | WIDTH | Asynchronous input pins |
| out_o | output | WIDTH | Per-line output value |
| oe_o | output | WIDTH | Per-line output enable |

## Verification
The bench builds four instances. The first is 16 lines wide, uses set/clear style with an input-polarity direction register, and has mirroring, byte swap and set readback all enabled. This makes every line remapping visible and lets the mixed set-register view be checked against known pin and latch values. The second is 8 lines wide, uses data-register style with no direction register and a plain bit order, which brings the two-flop latency and ignored absent registers within reach. The third is an 8-line set-only controller with an output-polarity direction register, and the fourth is an 8-line input-only data-style controller.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {WR_DATA, WR_SET_CLR, WR_SET_ONLY} wr_style_e;
  typedef enum logic [1:0] {DIR_NONE, DIR_OUT_POL, DIR_IN_POL} dir_mode_e;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_SET  = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [1:0] ADDR_DIR  = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/gpio_bit_order.sv
// Line <-> bus permutation; mirror and byte swap commute and are self-inverse.
module gpio_bit_order #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          MIRROR    = 1'b0,
  parameter bit          BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] y_o
);
  localparam int unsigned NBYTES = WIDTH / 8;
  logic [WIDTH-1:0] m;

  if (MIRROR) begin : g_mirror
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign m[i] = a_i[WIDTH-1-i];
    end
  end else begin : g_plain
    assign m = a_i;
  end

  if (BYTE_SWAP && NBYTES > 1) begin : g_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign y_o[8*b +: 8] = m[8*(NBYTES-1-b) +: 8];
    end
  end else begin : g_noswap
    assign y_o = m;
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter wr_style_e   STYLE     = WR_SET_CLR,
  parameter bit          NO_OUTPUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_data_i,
  input  logic             wr_set_i,
  input  logic             wr_clr_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    nxt = q_o;
    if (!NO_OUTPUT) begin
      unique case (STYLE)
        WR_DATA:     if (wr_data_i) nxt = val_i;
        WR_SET_ONLY: if (wr_set_i)  nxt = val_i;
        default: begin
          if (wr_set_i) nxt = q_o | val_i;
          if (wr_clr_i) nxt = q_o & ~val_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/gpio_dir_latch.sv
module gpio_dir_latch
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter dir_mode_e   MODE  = DIR_OUT_POL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] is_out_o,
  output logic [WIDTH-1:0] rd_o
);
  if (MODE == DIR_NONE) begin : g_none
    assign is_out_o = '1;
    assign rd_o     = '0;
  end else begin : g_reg
    logic [WIDTH-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= '0;
      else if (wr_i) q <= (MODE == DIR_IN_POL) ? ~val_i : val_i;
    end
    assign is_out_o = q;
    assign rd_o     = (MODE == DIR_IN_POL) ? ~q : q;
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH        = 32,
  parameter wr_style_e   STYLE        = WR_SET_CLR,
  parameter dir_mode_e   DIR_MODE     = DIR_OUT_POL,
  parameter bit          MIRROR       = 1'b0,
  parameter bit          BYTE_SWAP    = 1'b0,
  parameter bit          SET_READBACK = 1'b0,
  parameter bit          NO_OUTPUT    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] out_o,
  output logic [WIDTH-1:0] oe_o
);
  if (WIDTH != 8 && WIDTH != 16 && WIDTH != 32 && WIDTH != 64) begin : g_bad_width
    $error("gpio_ctrl: WIDTH must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && WIDTH == 64) begin : g_bad_swap
    $error("gpio_ctrl: byte swap not allowed at 64 bits");
  end

  logic             wr;
  logic [WIDTH-1:0] w_lines, r_lines, pin_s, is_out, dir_rd;

  assign wr = sel_i & wr_i;

  gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
    .a_i(wdata_i), .y_o(w_lines));
  gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
    .a_i(r_lines), .y_o(rdata_o));

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(pin_s));

  gpio_out_latch #(.WIDTH(WIDTH), .STYLE(STYLE), .NO_OUTPUT(NO_OUTPUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_data_i(wr && addr_i == ADDR_DATA),
    .wr_set_i (wr && addr_i == ADDR_SET),
    .wr_clr_i (wr && addr_i == ADDR_CLR),
    .val_i(w_lines), .q_o(out_o));

  gpio_dir_latch #(.WIDTH(WIDTH), .MODE(DIR_MODE)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && addr_i == ADDR_DIR),
    .val_i(w_lines), .is_out_o(is_out), .rd_o(dir_rd));

  assign oe_o = NO_OUTPUT ? '0 : is_out;

  always_comb begin
    r_lines = '0;
    unique case (addr_i)
      ADDR_DATA: r_lines = pin_s;
      ADDR_SET: if (STYLE != WR_DATA)
                  r_lines = SET_READBACK ? ((out_o & oe_o) | (pin_s & ~oe_o)) : out_o;
      ADDR_DIR:  r_lines = dir_rd;
      default:   r_lines = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH        = 32,
  parameter wr_style_e   STYLE        = WR_SET_CLR,
  parameter dir_mode_e   DIR_MODE     = DIR_OUT_POL,
  parameter bit          MIRROR       = 1'b0,
  parameter bit          BYTE_SWAP    = 1'b0,
  parameter bit          NO_OUTPUT    = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [WIDTH-1:0] pins_i,
  input logic [WIDTH-1:0] out_o,
  input logic [WIDTH-1:0] oe_o
);
  localparam bit PLAIN = !MIRROR && !BYTE_SWAP;
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_out_r2: assert (out_o == '0);
      if (DIR_MODE != DIR_NONE) p_reset_oe_r2: assert (oe_o == '0);
    end
  end

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> $stable(out_o));
  p_oe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i && addr_i == ADDR_DIR) |=> $stable(oe_o));
  p_clr_reads_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CLR) |-> (rdata_o == '0));

  if (PLAIN) begin : g_plain
    p_sync_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 2 && addr_i == ADDR_DATA) |-> (rdata_o == $past(pins_i, 2)));
    if (STYLE == WR_SET_CLR && !NO_OUTPUT) begin : g_sc
      p_set_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == ADDR_SET) |=> ((out_o & $past(wdata_i)) == $past(wdata_i)));
      p_clr_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == ADDR_CLR) |=> ((out_o & $past(wdata_i)) == '0));
    end
    if (DIR_MODE == DIR_OUT_POL && !NO_OUTPUT) begin : g_op
      p_dir_out_pol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == ADDR_DIR) |=> (oe_o == $past(wdata_i)));
    end
  end

  if (NO_OUTPUT) begin : g_noout
    p_input_only_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i |-> (out_o == '0 && oe_o == '0));
  end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .WIDTH(WIDTH), .STYLE(STYLE), .DIR_MODE(DIR_MODE), .MIRROR(MIRROR),
  .BYTE_SWAP(BYTE_SWAP), .NO_OUTPUT(NO_OUTPUT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pins_i(pins_i), .out_o(out_o), .oe_o(oe_o)
);

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  import gpio_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  sel = '0;
  logic        wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] pins0 = '0;
  logic [7:0]  pins1 = '0, pins2 = '0, pins3 = '0;
  logic [15:0] rd0, out0, oe0;
  logic [7:0]  rd1, out1, oe1, rd2, out2, oe2, rd3, out3, oe3;

  gpio_ctrl #(.WIDTH(16), .STYLE(WR_SET_CLR), .DIR_MODE(DIR_IN_POL), .MIRROR(1'b1),
              .BYTE_SWAP(1'b1), .SET_READBACK(1'b1), .NO_OUTPUT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel[0]), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd0), .pins_i(pins0), .out_o(out0), .oe_o(oe0));
  gpio_ctrl #(.WIDTH(8), .STYLE(WR_DATA), .DIR_MODE(DIR_NONE)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel[1]), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata[7:0]), .rdata_o(rd1), .pins_i(pins1), .out_o(out1), .oe_o(oe1));
  gpio_ctrl #(.WIDTH(8), .STYLE(WR_SET_ONLY), .DIR_MODE(DIR_OUT_POL)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel[2]), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata[7:0]), .rdata_o(rd2), .pins_i(pins2), .out_o(out2), .oe_o(oe2));
  gpio_ctrl #(.WIDTH(8), .STYLE(WR_DATA), .DIR_MODE(DIR_NONE), .NO_OUTPUT(1'b1)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel[3]), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata[7:0]), .rdata_o(rd3), .pins_i(pins3), .out_o(out3), .oe_o(oe3));

  // Bus view of a 16-line vector: line n -> bit 15-n, then bytes exchanged (R11, R12).
  function automatic logic [15:0] bus16(input logic [15:0] lines);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = lines[15-i];
    return {m[7:0], m[15:8]};
  endfunction

  typedef struct {
    int          inst;
    int          kind;   // 0 rdata, 1 out, 2 oe
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  function automatic logic [15:0] actual(int inst, int kind);
    case (inst)
      0: return kind == 0 ? rd0 : kind == 1 ? out0 : oe0;
      1: return {8'h0, kind == 0 ? rd1 : kind == 1 ? out1 : oe1};
      2: return {8'h0, kind == 0 ? rd2 : kind == 1 ? out2 : oe2};
      default: return {8'h0, kind == 0 ? rd3 : kind == 1 ? out3 : oe3};
    endcase
  endfunction

  // Monitor: compares every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] a;
      it = sb.pop_front();
      a = actual(it.inst, it.kind);
      checks++;
      if (a !== it.exp) begin
        errors++;
        $display("FAIL %s u%0d kind%0d: got %h expected %h", it.req, it.inst, it.kind, a, it.exp);
      end
    end
  end

  task automatic expect_now(int inst, int kind, logic [15:0] exp, string req);
    item_t it;
    it.inst = inst; it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic bus_wr(int inst, logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    sel = 4'(1 << inst); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = '0; wr = 1'b0;
  endtask

  task automatic rd_expect(int inst, logic [1:0] a, logic [15:0] exp, string req);
    @(posedge clk); #1;
    sel = 4'(1 << inst); addr = a;
    expect_now(inst, 0, exp, req);
    sel = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset values held while reset is low
    repeat (2) @(posedge clk); #1;
    expect_now(0, 1, 16'h0000, "R2 out");
    expect_now(0, 2, 16'h0000, "R2 oe");
    @(posedge clk); #1; rst_n = 1'b1;
    rd_expect(0, ADDR_DIR, bus16(16'hFFFF), "R9 dir reads all inputs after reset");
    expect_now(2, 2, 16'h0000, "R2 oe u2");
    expect_now(1, 2, 16'h00FF, "R10 no dir reg oe");

    // u0: set/clear with mirror and byte swap
    bus_wr(0, ADDR_SET, bus16(16'h0005));
    expect_now(0, 1, 16'h0005, "R4 R11 R12 set");
    bus_wr(0, ADDR_CLR, bus16(16'h0001));
    expect_now(0, 1, 16'h0004, "R4 clr keeps zero bits");
    bus_wr(0, ADDR_SET, bus16(16'h8000));
    expect_now(0, 1, 16'h8004, "R1 top line");
    bus_wr(0, ADDR_DIR, bus16(16'hFFF0));
    expect_now(0, 2, 16'h000F, "R9 in-pol oe");
    rd_expect(0, ADDR_DIR, bus16(16'hFFF0), "R9 dir readback");

    // R3: two-edge synchroniser latency
    @(posedge clk); #1;
    addr = ADDR_DATA; pins0 = 16'hA5A0;
    expect_now(0, 0, 16'h0000, "R3 before edge");
    @(posedge clk); #1;
    expect_now(0, 0, 16'h0000, "R3 after one edge");
    @(posedge clk); #1;
    expect_now(0, 0, bus16(16'hA5A0), "R3 after two edges");

    rd_expect(0, ADDR_SET, bus16(16'hA5A4), "R13 set readback mix");
    rd_expect(0, ADDR_CLR, 16'h0000, "R4 clr reads zero");

    // u1: data-register style, no direction register
    bus_wr(1, ADDR_DATA, 16'h003C);
    expect_now(1, 1, 16'h003C, "R6 data write");
    expect_now(0, 1, 16'h8004, "R7 unselected u0 unchanged");
    bus_wr(1, ADDR_SET, 16'h00FF);
    expect_now(1, 1, 16'h003C, "R7 absent set ignored");
    rd_expect(1, ADDR_DIR, 16'h0000, "R10 dir addr reads zero");
    @(posedge clk); #1; pins1 = 8'h5A;
    repeat (3) @(posedge clk);
    rd_expect(1, ADDR_DATA, 16'h005A, "R6 data read is pins");

    // u2: set-only, output polarity
    bus_wr(2, ADDR_SET, 16'h0081);
    expect_now(2, 1, 16'h0081, "R5 set-only load");
    bus_wr(2, ADDR_SET, 16'h0001);
    expect_now(2, 1, 16'h0001, "R5 zero drives low");
    bus_wr(2, ADDR_CLR, 16'h00FF);
    expect_now(2, 1, 16'h0001, "R7 absent clr ignored");
    bus_wr(2, ADDR_DIR, 16'h000F);
    expect_now(2, 2, 16'h000F, "R8 out-pol oe");
    rd_expect(2, ADDR_DIR, 16'h000F, "R8 dir readback");
    @(posedge clk); #1; pins2 = 8'hF0;
    repeat (3) @(posedge clk);
    rd_expect(2, ADDR_SET, 16'h0001, "R13 readback off returns latch");

    // u3: input only
    bus_wr(3, ADDR_DATA, 16'h00FF);
    expect_now(3, 1, 16'h0000, "R14 out stays zero");
    expect_now(3, 2, 16'h0000, "R14 oe stays zero");

    @(posedge clk); #1;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule